// File: doc/BRIEF.md
# Capture/Compare Unit with Timer-Clear Trigger

The unit watches a 16-bit free-running timer that lives outside it. In capture mode it records the timer value into its single capture/compare register whenever the chosen edge of an external event line arrives. The event line is first passed through a two-stage synchronizer. In compare mode it checks the timer against that register on every clock. On equality it sets its interrupt flag. In the trigger variant it also drives a timer-clear strobe, so the register acts as the timer's period.

The clear is a separate strobe that the timer applies as a load of zero. It is not a count past the top value, so the timer's own wrap detection never sees it and its rollover interrupt stays quiet. The unit still raises its own flag on that match. The clear only lands reliably when the timer is clocked from the same clock as this unit.

The control state machine has four states: ST_OFF, ST_CAPTURE, ST_CMP_FLAG and ST_CMP_CLEAR. Reset enters ST_OFF. A write to the control address moves the machine to the state coded in the mode field. That gives the transitions off-to-capture, off-to-compare, capture-to-compare, compare-to-off, and so on, any state to any state. No other event changes state.

Top module: `capcmp_unit`

## Requirements
- R1: After reset the unit is in ST_OFF, `ccr_out` is 0, `irq_flag` is 0 and `timer_clr` is 0.
- R2: A write with `wr_addr`=0 loads control, where bits 1:0 are the mode (00 off, 01 capture, 10 compare with flag, 11 compare with timer clear) and bit 2 is the edge select. A write with `wr_addr`=1 loads the register from `wr_data`. Both take effect at the next clock edge. A write with `wr_addr`=3 changes nothing.
- R3: In capture mode, a selected edge on `evt_in` stores the `timer_val` present at the third rising clock edge after the input changes, and it sets `irq_flag` at that same edge.
- R4: Edge select 0 captures on rising edges of `evt_in`, and edge select 1 captures on falling edges. The opposite edge captures nothing.
- R5: In either compare mode, `timer_val` equal to the register sets `irq_flag` at the next clock edge.
- R6: In mode 11, `timer_clr` is high in exactly the cycles where `timer_val` equals the register. In mode 10 it stays low.
- R7: `irq_flag` stays set until a write with `wr_addr`=2. If a capture or match happens in the same cycle as that write, the flag stays set.
- R8: A register write and a capture in the same cycle leave the written value in the register.
- R9: In mode off, events and equality change neither the register nor the flag, and `timer_clr` stays low.
- R10: In capture mode, equality between the timer and the register has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Current value of the shared timer |
| evt_in | input | 1 | Asynchronous event line for capture |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 register, 2 flag clear, 3 unused |
| wr_data | input | 16 | Write data |
| ccr_out | output | 16 | Capture/compare register contents |
| irq_flag | output | 1 | Sticky interrupt flag |
| timer_clr | output | 1 | Strobe telling the timer to load zero |

## Verification
Two pairs of events can fall in the same cycle. The first is a software register write and a recognised capture edge. The second is a flag-clear write and a capture or compare hit. The bench provokes both by counting the synchronizer latency: it raises the event line two clocks before it issues the write. It also parks the timer on the register value and then writes the flag clear. A behavioural model, built from a queue of past event samples and plain variables, predicts that the written data survives the capture and that the flag remains set. Those predictions are compared on every clock alongside the timer-period behaviour in clear mode.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    typedef enum logic [1:0] {
        ST_OFF       = 2'b00,
        ST_CAPTURE   = 2'b01,
        ST_CMP_FLAG  = 2'b10,
        ST_CMP_CLEAR = 2'b11
    } cc_state_e;

    localparam logic [1:0] ADDR_CTRL     = 2'd0;
    localparam logic [1:0] ADDR_REG      = 2'd1;
    localparam logic [1:0] ADDR_FLAG_CLR = 2'd2;
    localparam int         EDGE_SEL_BIT  = 2;
endpackage

// File: rtl/capcmp_edge_sync.sv
module capcmp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic fall_sel,
    output logic hit
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              s_now;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign s_now = sync_q[TOP];

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s_now;
    end

    assign hit = fall_sel ? (!s_now && prev_q) : (s_now && !prev_q);
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
    parameter int TW = 16
) (
    input  logic          en,
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] ref_val,
    output logic          eq
);
    assign eq = en && (timer_val == ref_val);
endmodule

// File: rtl/capcmp_core.sv
module capcmp_core
    import capcmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic [TW-1:0] timer_val,
    input  logic          edge_hit,
    input  logic          tmr_eq,
    output logic          fall_sel,
    output logic          cmp_en,
    output logic [TW-1:0] ccr_q,
    output logic          flag_q,
    output logic          timer_clr
);
    cc_state_e state_q, state_d;
    logic      cap_arm, clr_arm, cap_evt;
    logic      ctrl_wr, reg_wr, clr_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign reg_wr  = wr_en && (wr_addr == ADDR_REG);
    assign clr_wr  = wr_en && (wr_addr == ADDR_FLAG_CLR);

    // next-state: only control writes move the machine
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case (wr_data[1:0])
                2'b00: state_d = ST_OFF;
                2'b01: state_d = ST_CAPTURE;
                2'b10: state_d = ST_CMP_FLAG;
                2'b11: state_d = ST_CMP_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        cap_arm = 1'b0;
        cmp_en  = 1'b0;
        clr_arm = 1'b0;
        unique case (state_q)
            ST_OFF:       ;
            ST_CAPTURE:   cap_arm = 1'b1;
            ST_CMP_FLAG:  cmp_en  = 1'b1;
            ST_CMP_CLEAR: begin
                cmp_en  = 1'b1;
                clr_arm = 1'b1;
            end
        endcase
    end

    assign cap_evt   = cap_arm && edge_hit;
    assign timer_clr = clr_arm && tmr_eq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_sel <= 1'b0;
            ccr_q    <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (ctrl_wr) fall_sel <= wr_data[EDGE_SEL_BIT];
            if (reg_wr)       ccr_q <= wr_data;
            else if (cap_evt) ccr_q <= timer_val;
            if (cap_evt || tmr_eq) flag_q <= 1'b1;
            else if (clr_wr)       flag_q <= 1'b0;
        end
    end

    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wr) |=> flag_q);
    assert_capture_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && edge_hit && !reg_wr) |=> (ccr_q == $past(timer_val)));
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (ccr_q == $past(wr_data)));
    assert_clear_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr |=> flag_q);
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !flag_q) |=> !flag_q);
    assert_off_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> !timer_clr);
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit #(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_val,
    input  logic          evt_in,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    output logic [TW-1:0] ccr_out,
    output logic          irq_flag,
    output logic          timer_clr
);
    logic fall_sel, edge_hit, cmp_en, tmr_eq;

    capcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(evt_in),
        .fall_sel(fall_sel), .hit(edge_hit)
    );

    capcmp_match #(.TW(TW)) u_match (
        .en(cmp_en), .timer_val(timer_val), .ref_val(ccr_out), .eq(tmr_eq)
    );

    capcmp_core #(.TW(TW)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .timer_val(timer_val), .edge_hit(edge_hit),
        .tmr_eq(tmr_eq), .fall_sel(fall_sel), .cmp_en(cmp_en),
        .ccr_q(ccr_out), .flag_q(irq_flag), .timer_clr(timer_clr)
    );

    assert_clr_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr |-> (timer_val == ccr_out));
endmodule

// File: tb/capcmp_unit_test.sv
module capcmp_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] timer_val = 0;
    logic        evt_in = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] ccr_out;
    logic        irq_flag, timer_clr;

    int checks = 0, errors = 0;
    string cur = "R1";

    // behavioural reference
    int          m_mode = 0;
    bit          m_fall = 0;
    int          m_ccr = 0;
    bit          m_flag = 0;
    bit          evq[$];
    int          tcnt = 0;
    bit          tick = 0;

    always #5 clk = ~clk;

    capcmp_unit uut (
        .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .evt_in(evt_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ccr_out(ccr_out), .irq_flag(irq_flag), .timer_clr(timer_clr)
    );

    function automatic bit exp_clr();
        return (m_mode == 3) && (int'(timer_val) == m_ccr);
    endfunction

    always @(posedge clk) begin
        bit hit, cap, mt, clr_now;
        if (!rst_n) begin
            m_mode = 0; m_fall = 0; m_ccr = 0; m_flag = 0;
            evq = '{0, 0, 0};
        end else begin
            clr_now = exp_clr();
            hit = m_fall ? (!evq[1] && evq[0]) : (evq[1] && !evq[0]);
            cap = (m_mode == 1) && hit;
            mt  = (m_mode >= 2) && (int'(timer_val) == m_ccr);
            if (wr_en && wr_addr == 1) m_ccr = int'(wr_data);
            else if (cap)              m_ccr = int'(timer_val);
            if (cap || mt) m_flag = 1;
            else if (wr_en && wr_addr == 2) m_flag = 0;
            if (wr_en && wr_addr == 0) begin
                m_mode = int'(wr_data[1:0]);
                m_fall = wr_data[2];
            end
            evq.push_back(evt_in);
            void'(evq.pop_front());
            if (tick) tcnt = clr_now ? 0 : ((tcnt + 1) & 16'hFFFF);
        end
    end

    task automatic fail16(string tag, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic expect_val(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) fail16(tag, what, act, exp);
    endtask

    task automatic compare();
        checks++;
        if (int'(ccr_out) != m_ccr) fail16(cur, "ccr_out", int'(ccr_out), m_ccr);
        else if (irq_flag !== m_flag) fail16(cur, "irq_flag", int'(irq_flag), int'(m_flag));
        else if (timer_clr !== exp_clr()) fail16(cur, "timer_clr", int'(timer_clr), int'(exp_clr()));
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            timer_val = tcnt[15:0];
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic set_timer(int v);
        tcnt = v; timer_val = v[15:0];
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int clr_seen, max_tv;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur = "R1";
        cyc(2);
        expect_val("R1", "ccr_out", int'(ccr_out), 0);
        expect_val("R1", "irq_flag", int'(irq_flag), 0);

        cur = "R2";
        wr(1, 16'h1234);
        expect_val("R2", "ccr_out", int'(ccr_out), 16'h1234);
        wr(3, 16'hFFFF);
        expect_val("R2", "ccr_out after addr3", int'(ccr_out), 16'h1234);
        expect_val("R2", "irq_flag after addr3", int'(irq_flag), 0);

        cur = "R3";
        tick = 1;
        wr(0, 16'h0001);
        cyc(3);
        evt_in = 1; cyc(5);
        expect_val("R3", "irq_flag", int'(irq_flag), 1);
        evt_in = 0; cyc(4);
        wr(2, 0);
        evt_in = 1; cyc(); cyc();
        expect_val("R3", "flag before capture", int'(irq_flag), 0);
        cyc();
        expect_val("R3", "flag at capture", int'(irq_flag), 1);

        cur = "R4";
        wr(0, 16'h0005);
        wr(2, 0);
        cyc(4);
        evt_in = 0; cyc(5);
        expect_val("R4", "falling capture flag", int'(irq_flag), 1);
        wr(2, 0);
        evt_in = 1; cyc(6);
        expect_val("R4", "rising ignored", int'(irq_flag), 0);

        cur = "R8";
        wr(0, 16'h0001);
        evt_in = 0; cyc(4);
        wr(2, 0);
        evt_in = 1; cyc(); cyc();
        wr(1, 16'hBEEF);
        expect_val("R8", "write beats capture", int'(ccr_out), 16'hBEEF);
        expect_val("R8", "capture flag", int'(irq_flag), 1);
        cyc(3);

        cur = "R10";
        wr(2, 0);
        tick = 0;
        wr(1, 16'd77);
        set_timer(77);
        cyc(4);
        expect_val("R10", "no compare in capture", int'(irq_flag), 0);

        cur = "R9";
        wr(0, 16'h0000);
        evt_in = 0; cyc(3); evt_in = 1; cyc(6);
        expect_val("R9", "ccr kept", int'(ccr_out), 77);
        expect_val("R9", "flag kept low", int'(irq_flag), 0);

        cur = "R5";
        wr(1, 16'd30);
        set_timer(20); tick = 1;
        wr(0, 16'h0002);
        cyc(5);
        expect_val("R5", "flag before equal", int'(irq_flag), 0);
        cyc(10);
        expect_val("R5", "flag after equal", int'(irq_flag), 1);

        cur = "R7";
        tick = 0; set_timer(30);
        cyc();
        wr(2, 0);
        expect_val("R7", "set beats clear", int'(irq_flag), 1);
        set_timer(31); cyc(3);
        expect_val("R7", "still sticky", int'(irq_flag), 1);
        wr(2, 0);
        expect_val("R7", "cleared", int'(irq_flag), 0);

        cur = "R6";
        wr(1, 16'd9);
        set_timer(0); tick = 1;
        wr(0, 16'h0003);
        clr_seen = 0; max_tv = 0;
        for (int i = 0; i < 45; i++) begin
            cyc();
            if (timer_clr) clr_seen++;
            if (int'(timer_val) > max_tv) max_tv = int'(timer_val);
        end
        checks++;
        if (clr_seen < 3) begin
            errors++;
            $display("FAIL R6 clear count actual=%0d expected>=3", clr_seen);
        end
        expect_val("R6", "timer period top", max_tv, 9);
        wr(0, 16'h0002);
        clr_seen = 0;
        for (int i = 0; i < 30; i++) begin
            cyc();
            if (timer_clr) clr_seen++;
        end
        expect_val("R6", "no clear in flag-only mode", clr_seen, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule